// File: doc/BRIEF.md
# Quad-Lane Double-Data-Rate Sample Serializer

This block takes four parallel 12-bit converter samples, one per lane, and sends each one out on its own serial lane. Both levels of a bit clock carry data, so the bit clock runs at six times the sample rate while each lane carries twelve bits per sample period. A frame clock at the sample rate marks where each word begins. Samples are offset-binary coded, so the midscale code is 1000 0000 0000.

All logic runs on one fast system clock. Two single-cycle enables stand in for the clocks: `slot_en` marks each serial bit slot and comes from a rate-multiplying clock source outside the block, and `smp_stb` marks each rising edge of the sample clock. A two-bit selector can force fixed alignment words onto every lane while both output clocks keep running. A power-down input turns off the lane drivers. A lock monitor counts bit slots per sample period and holds `out_valid` low until the slot rate has been steady for 100 sample periods.

Top module: `ddr_quad_ser`

## Requirements
- R1: On every cycle with `smp_stb` high, lane i captures `smp_data[12*i+11:12*i]` into a holding register. Each frame sends the word that was held when the frame was loaded. A word captured while a frame is in flight does not change that frame; it goes out in a later frame.
- R2: A frame is 12 consecutive `slot_en` cycles. Each lane sends its word MSB first, one bit per slot, and `lane_dat` changes only on clock edges where `slot_en` is high.
- R3: `dco` is high during even bit slots (0, 2, ..., 10) and low during odd ones. Each of its levels therefore spans exactly one bit, giving six periods per frame.
- R4: `fco` is high during bit slots 0 to 5 and low during slots 6 to 11, so its rising edge coincides with the MSB.
- R5: `pat_sel` is read when a frame is loaded and applies to all lanes. 2'b00 sends sample data, 2'b01 sends 1000 0000 0000 (0x800), 2'b10 sends 1010 1010 1010 (0xAAA), and the reserved value 2'b11 sends sample data.
- R6: While a test pattern is selected, `dco` and `fco` follow exactly the sequences of R3 and R4.
- R7: `lane_oe` goes low in the cycle after `pwr_dn` is sampled high and returns high in the cycle after `pwr_dn` is sampled low. `out_valid` is low in every cycle after a cycle in which `pwr_dn` was high.
- R8: After reset, the first `smp_stb` serves as a reference. `out_valid` rises in the cycle after the `smp_stb` that closes the 100th consecutive sample period containing exactly 12 `slot_en` cycles. A period is counted from the cycle after one strobe up to and including the cycle of the next strobe.
- R9: A sample period whose slot count is not 12 pulls `out_valid` low in the cycle after the strobe that closes it, and the count of 100 good periods starts again from zero.
- R10: After `pwr_dn` returns low, the first `smp_stb` is again only a reference, and `out_valid` rises after 100 more good periods, as in R8.
- R11: While `rst_n` is low, `out_valid` is 0, `lane_dat` is all zeros, `fco` and `dco` are 1, and `lane_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than or equal to the bit-slot rate |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | One pulse per serial bit slot (12 per sample period) |
| smp_stb | input | 1 | One pulse per sample-clock rising edge |
| smp_data | input | 48 | Four 12-bit offset-binary samples, lane i at bits 12*i+11 down to 12*i |
| pat_sel | input | 2 | 00 data, 01 midscale word, 10 alternating word, 11 data |
| pwr_dn | input | 1 | High turns the lane drivers off and drops lock |
| lane_dat | output | 4 | Serial bit of each lane |
| lane_oe | output | 1 | Drive enable for the lane pads; low means high impedance |
| dco | output | 1 | Bit clock, one level per bit |
| fco | output | 1 | Frame clock, high for the first half of each word |
| out_valid | output | 1 | Slot rate has been stable long enough to trust the lanes |

## Verification
The hardest case to reach from the ports is a sample-rate change followed by relock. Here the slot count per strobe has to be wrong for a known number of periods and then right for exactly 100 periods, and `out_valid` must be observed in the cycle just before and just after the strobe that completes the count. The bench produces strobes from its own phase counter with an adjustable period. It changes that period only in the cycle right after a strobe, so it knows which strobe closes a bad period and which closes the 100th good one. A similar edge case is a new word captured while a frame is in flight. The bench changes `smp_data` right after a frame-clock rise and checks that the frame in progress still carries the old word.

// File: rtl/ddr_quad_ser.sv
`timescale 1ns/1ps
module ddr_quad_ser #(
  parameter int LANES  = 4,
  parameter int WBITS  = 12,
  parameter int LOCK_N = 100,
  parameter int CNT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   slot_en,
  input  logic                   smp_stb,
  input  logic [LANES*WBITS-1:0] smp_data,
  input  logic [1:0]             pat_sel,
  input  logic                   pwr_dn,
  output logic [LANES-1:0]       lane_dat,
  output logic                   lane_oe,
  output logic                   dco,
  output logic                   fco,
  output logic                   out_valid
);
  localparam int SLOT_W = $clog2(WBITS);
  localparam int LOCK_W = $clog2(LOCK_N + 1);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(WBITS - 1);
  localparam logic [SLOT_W-1:0] HALF = SLOT_W'(WBITS / 2);

  function automatic logic [WBITS-1:0] alt_word();
    logic [WBITS-1:0] w;
    for (int i = 0; i < WBITS; i++) w[i] = i[0];
    return w;
  endfunction

  localparam logic [WBITS-1:0] PAT_MID = {1'b1, {(WBITS-1){1'b0}}};
  localparam logic [WBITS-1:0] PAT_ALT = alt_word();

  logic [SLOT_W-1:0] slot_q;
  logic              pd_q;
  logic              ref_q;
  logic [CNT_W-1:0]  spc_q;
  logic [LOCK_W-1:0] lock_q;

  wire frame_end = slot_en && (slot_q == LAST);
  wire [CNT_W:0] meas = {1'b0, spc_q} + {{CNT_W{1'b0}}, slot_en};
  wire period_ok = (meas == (CNT_W+1)'(WBITS));

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else if (slot_en) slot_q <= frame_end ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= pwr_dn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_dn) begin
      ref_q  <= 1'b0;
      spc_q  <= '0;
      lock_q <= '0;
    end else if (smp_stb) begin
      spc_q <= '0;
      ref_q <= 1'b1;
      if (ref_q) begin
        if (!period_ok)                     lock_q <= '0;
        else if (lock_q != LOCK_W'(LOCK_N)) lock_q <= lock_q + 1'b1;
      end
    end else if (slot_en && spc_q != '1) begin
      spc_q <= spc_q + 1'b1;
    end
  end

  assign dco       = ~slot_q[0];
  assign fco       = slot_q < HALF;
  assign lane_oe   = ~pd_q;
  assign out_valid = (lock_q == LOCK_W'(LOCK_N));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WBITS-1:0] hold_q;
    logic [WBITS-1:0] sh_q;
    logic [WBITS-1:0] nxt;

    always_comb begin
      case (pat_sel)
        2'b01:   nxt = PAT_MID;
        2'b10:   nxt = PAT_ALT;
        default: nxt = hold_q;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q <= '0;
        sh_q   <= '0;
      end else begin
        if (smp_stb) hold_q <= smp_data[i*WBITS +: WBITS];
        if (slot_en) sh_q <= frame_end ? nxt : {sh_q[WBITS-2:0], 1'b0};
      end
    end

    assign lane_dat[i] = sh_q[WBITS-1];

    // R5
    pat_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && pat_sel == 2'b01) |=> (sh_q == PAT_MID));

    // R5
    pat_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && pat_sel == 2'b10) |=> (sh_q == PAT_ALT));

    // R2
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_en |=> $stable(lane_dat[i]));
  end

  // R7
  pd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !lane_oe);

  // R7
  pd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !out_valid);

  // R3
  dco_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dco) |-> $past(slot_en));

  // R4
  fco_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fco) |-> ($past(slot_en) && dco));

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(smp_stb));
endmodule

// File: tb/sim_ddr_quad_ser.sv
`timescale 1ns/1ps
module sim_ddr_quad_ser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_en = 1'b1;
  logic        smp_stb = 1'b0;
  logic [47:0] smp_data = '0;
  logic [1:0]  pat_sel = 2'b00;
  logic        pwr_dn = 1'b0;
  logic [3:0]  lane_dat;
  logic        lane_oe, dco, fco, out_valid;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  bit gen_on = 0;
  int gen_per = 12;
  int ph = 0;
  int n_stb = 0;

  localparam logic [47:0] WA = {12'h7FE, 12'h801, 12'h3C9, 12'hA53};
  localparam logic [47:0] WB = {12'h5B6, 12'h000, 12'hFFF, 12'h124};

  ddr_quad_ser u0 (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .smp_stb(smp_stb),
    .smp_data(smp_data), .pat_sel(pat_sel), .pwr_dn(pwr_dn),
    .lane_dat(lane_dat), .lane_oe(lane_oe), .dco(dco), .fco(fco),
    .out_valid(out_valid)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (gen_on) begin
      if (ph == 0) begin
        smp_stb = 1'b1;
        n_stb++;
      end else begin
        smp_stb = 1'b0;
      end
      ph = (ph + 1) % gen_per;
    end else begin
      smp_stb = 1'b0;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_stb(input int k);
    while (n_stb != k) step();
  endtask

  task automatic lock_edge(input int k, input string req);
    wait_stb(k);
    chk(out_valid == 1'b0, req, "valid before last good strobe", out_valid, 0);
    step();
    chk(out_valid == 1'b1, req, "valid after last good strobe", out_valid, 1);
  endtask

  task automatic get_frame(output logic [3:0][11:0] w, output bit clk_ok,
                           input bit chg, input logic [47:0] nd);
    logic pf;
    pf = fco;
    clk_ok = 1;
    forever begin
      step();
      if (fco && !pf) break;
      pf = fco;
    end
    for (int b = 0; b < 12; b++) begin
      if (b > 0) step();
      for (int l = 0; l < 4; l++) w[l][11-b] = lane_dat[l];
      if (dco != (b % 2 == 0)) clk_ok = 0;
      if (fco != (b < 6)) clk_ok = 0;
      if (b == 0 && chg) smp_data = nd;
    end
  endtask

  task automatic do_reset();
    step();
    gen_on = 0;
    rst_n = 0;
    repeat (3) step();
    // R11
    chk(out_valid == 1'b0, "R11", "reset out_valid", out_valid, 0);
    chk(lane_dat == 4'h0, "R11", "reset lane_dat", lane_dat, 0);
    chk(fco == 1'b1, "R11", "reset fco", fco, 1);
    chk(dco == 1'b1, "R11", "reset dco", dco, 1);
    chk(lane_oe == 1'b1, "R11", "reset lane_oe", lane_oe, 1);
    n_stb = 0;
    ph = 0;
    gen_per = 12;
    rst_n = 1;
    gen_on = 1;
  endtask

  task automatic t_lock_reset();
    // R8: strobe 1 is the reference, strobe 101 closes the 100th good period
    lock_edge(101, "R8");
  endtask

  task automatic t_serial();
    logic [3:0][11:0] w;
    bit ok;
    get_frame(w, ok, 0, '0);
    get_frame(w, ok, 0, '0);
    for (int l = 0; l < 4; l++)
      chk(w[l] == WA[12*l +: 12], "R2", $sformatf("lane %0d word", l), w[l], WA[12*l +: 12]);
    chk(ok, "R3", "dco/fco sequence in frame", ok, 1);
    chk(ok, "R4", "fco high slots 0-5", ok, 1);
  endtask

  task automatic t_midframe();
    logic [3:0][11:0] w;
    bit ok;
    // R1: change data right after the frame start
    get_frame(w, ok, 1, WB);
    for (int l = 0; l < 4; l++)
      chk(w[l] == WA[12*l +: 12], "R1", $sformatf("in-flight lane %0d", l), w[l], WA[12*l +: 12]);
    get_frame(w, ok, 0, '0);
    get_frame(w, ok, 0, '0);
    for (int l = 0; l < 4; l++)
      chk(w[l] == WB[12*l +: 12], "R1", $sformatf("new word lane %0d", l), w[l], WB[12*l +: 12]);
  endtask

  task automatic t_pattern(input logic [1:0] sel, input logic [11:0] exp_all,
                           input bit use_data);
    logic [3:0][11:0] w;
    bit ok;
    logic [11:0] e;
    pat_sel = sel;
    get_frame(w, ok, 0, '0);
    get_frame(w, ok, 0, '0);
    for (int l = 0; l < 4; l++) begin
      e = use_data ? smp_data[12*l +: 12] : exp_all;
      chk(w[l] == e, "R5", $sformatf("sel %0d lane %0d", sel, l), w[l], e);
    end
    chk(ok, "R6", $sformatf("clocks under sel %0d", sel), ok, 1);
  endtask

  task automatic t_rate();
    int n0;
    n0 = n_stb;
    wait_stb(n0 + 1);
    chk(out_valid == 1'b1, "R9", "valid before rate change", out_valid, 1);
    gen_per = 24;
    wait_stb(n0 + 2);
    chk(out_valid == 1'b1, "R9", "valid before bad strobe acts", out_valid, 1);
    step();
    chk(out_valid == 1'b0, "R9", "valid after bad period", out_valid, 0);
    wait_stb(n0 + 3);
    gen_per = 12;
    // R9: strobes n0+4 .. n0+103 close 100 good periods
    wait_stb(n0 + 60);
    chk(out_valid == 1'b0, "R9", "valid mid relock", out_valid, 0);
    lock_edge(n0 + 103, "R9");
  endtask

  task automatic t_pdown();
    int n0;
    n0 = n_stb;
    wait_stb(n0 + 1);
    step();
    pwr_dn = 1;
    step();
    chk(lane_oe == 1'b0, "R7", "lane_oe in power-down", lane_oe, 0);
    chk(out_valid == 1'b0, "R7", "valid in power-down", out_valid, 0);
    repeat (30) step();
    chk(lane_oe == 1'b0, "R7", "lane_oe held off", lane_oe, 0);
    n0 = n_stb;
    wait_stb(n0 + 1);
    step();
    n0 = n_stb;
    pwr_dn = 0;
    step();
    chk(lane_oe == 1'b1, "R7", "lane_oe after release", lane_oe, 1);
    // R10: strobe n0+1 is the reference
    lock_edge(n0 + 101, "R10");
  endtask

  initial begin
    smp_data = WA;
    do_reset();
    t_lock_reset();
    t_serial();
    t_midframe();
    t_pattern(2'b01, 12'h800, 0);
    t_pattern(2'b10, 12'hAAA, 0);
    t_pattern(2'b11, 12'h000, 1);
    t_pattern(2'b00, 12'h000, 1);
    t_rate();
    t_pdown();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule